// File: doc/BRIEF.md
# Dual-Exponent Modular Power Sequencer

This block is the control engine for a two-base modular exponentiation. It produces g0^e0 · g1^e1 mod m by sending a stream of multiply commands to an external Montgomery multiplier. The multiplier works on four operand slots. Slot 0 holds g0 in Montgomery form and slot 1 holds g1 in Montgomery form. Slot 2 holds the product of those two. Slot 3 is the accumulator, loaded beforehand with R mod m. The sequencer never sees operand data. It only chooses which slots the multiplier reads and writes, and it paces the commands against the multiplier's completion signal.

Both exponents are processed together, one bit pair at a time. Their bits come from a show-ahead FIFO of 32-bit words. Each word carries a 16-bit chunk of e1 in its upper half and the matching chunk of e0 in its lower half. The most significant chunk is pushed first. For every bit pair the accumulator is squared. It is then multiplied by one of the three precomputed operands, unless both bits are zero. When the FIFO is found empty at a word boundary, a one-cycle done pulse is raised, which software can use as its interrupt.

Top module: `simexp_seq`

## Requirements
- R1: After a synchronous reset, `mul_go_o`, `fifo_rd_o` and `done_o` are low and no command is issued until a start is accepted.
- R2: A start pulse is accepted only while `exp_mode_i` is high. A start with `exp_mode_i` low has no effect: no FIFO read, no multiply command and no done pulse follow.
- R3: In each FIFO word, bits 31:16 are a chunk of e1 and bits 15:0 are the same-weight chunk of e0. Words are consumed in FIFO order, the first word being the most significant chunk. Within a word, bit pairs {e1[i], e0[i]} are handled for i from 15 down to 0.
- R4: Every bit pair begins with a squaring command: x select 3, y select 3, destination 3.
- R5: After the squaring, pair value {e1,e0} = 01 issues a multiply with y select 0, 10 uses y select 1, and 11 uses y select 2. In each case x select is 3 and the destination is 3. Pair 00 issues no multiply.
- R6: `mul_go_o` is high for exactly one cycle per command. No new command is issued until `mul_done_i` has been seen for the previous one.
- R7: With slots holding g0, g1, g0·g1 and the multiplicative identity, the accumulator finally holds g0^e0 · g1^e1 mod m.
- R8: A run over N words issues exactly 16·N squarings plus one multiply per nonzero bit pair. `fifo_rd_o` pulses once per word consumed.
- R9: A start accepted while the FIFO is empty raises `done_o` on the second rising edge after the start is sampled, with no multiply command.
- R10: `done_o` is a single-cycle pulse, raised only after the last command's done once the FIFO is found empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| exp_mode_i | input | 1 | Exponentiation mode qualifier for start |
| fifo_empty_i | input | 1 | Exponent FIFO empty flag |
| fifo_data_i | input | 32 | Head word of the show-ahead FIFO |
| fifo_rd_o | output | 1 | Pop strobe for the FIFO head word |
| mul_x_o | output | 2 | Multiplier x operand slot |
| mul_y_o | output | 2 | Multiplier y operand slot |
| mul_dest_o | output | 2 | Multiplier destination slot |
| mul_go_o | output | 1 | One-cycle multiplier command strobe |
| mul_done_i | input | 1 | Multiplier completion pulse |
| done_o | output | 1 | End-of-exponentiation pulse |

## Verification
Command timing: a command strobe appears one cycle after the sequencer enters its issue state. A squaring follows one cycle after a word is fetched or after the previous pair finishes. A pair's multiply follows two cycles after the squaring's done. The end pulse comes two edges after start on an empty FIFO, or two edges after the last done plus the fetch that finds the FIFO empty. The bench drives inputs on falling edges and samples one time unit after rising edges. A multiplier stub with a per-vector latency of 1 to 4 cycles computes real modular products. The result, the squaring and multiply counts and the pop count are therefore compared after done against values worked out independently. The empty-start case is checked at the exact edge at which done is due.

// File: rtl/simexp_seq_pkg.sv
package simexp_seq_pkg;
  localparam int SLOT_W = 2;

  localparam logic [SLOT_W-1:0] SLOT_G0  = 2'd0;
  localparam logic [SLOT_W-1:0] SLOT_G1  = 2'd1;
  localparam logic [SLOT_W-1:0] SLOT_G01 = 2'd2;
  localparam logic [SLOT_W-1:0] SLOT_ACC = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_SQ,
    ST_SQ_WAIT,
    ST_MU,
    ST_MU_WAIT,
    ST_NEXT
  } seq_state_t;
endpackage

// File: rtl/simexp_word_reg.sv
module simexp_word_reg #(
  parameter int CHUNK_W = 16,
  localparam int FIFO_W = 2 * CHUNK_W,
  localparam int CNT_W  = $clog2(CHUNK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [FIFO_W-1:0] word_i,
  output logic [1:0]        pair_o,
  output logic              last_o
);
  logic [CHUNK_W-1:0] e0_q, e1_q;
  logic [CNT_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      e0_q   <= '0;
      e1_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      e0_q   <= word_i[CHUNK_W-1:0];
      e1_q   <= word_i[FIFO_W-1:CHUNK_W];
      left_q <= CNT_W'(CHUNK_W - 1);
    end else if (shift_i) begin
      e0_q   <= {e0_q[CHUNK_W-2:0], 1'b0};
      e1_q   <= {e1_q[CHUNK_W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end
  end

  assign pair_o = {e1_q[CHUNK_W-1], e0_q[CHUNK_W-1]};
  assign last_o = (left_q == '0);

  p_no_shift_past_end_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |-> (left_q != '0));
endmodule

// File: rtl/simexp_pair_map.sv
module simexp_pair_map
  import simexp_seq_pkg::*;
(
  input  logic [1:0]        pair_i,
  output logic [SLOT_W-1:0] y_slot_o,
  output logic              need_mul_o
);
  always_comb begin
    need_mul_o = 1'b1;
    unique case (pair_i)
      2'b01:   y_slot_o = SLOT_G0;
      2'b10:   y_slot_o = SLOT_G1;
      2'b11:   y_slot_o = SLOT_G01;
      default: begin
        y_slot_o   = SLOT_ACC;
        need_mul_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/simexp_cmd_port.sv
module simexp_cmd_port
  import simexp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [SLOT_W-1:0] x_i,
  input  logic [SLOT_W-1:0] y_i,
  input  logic [SLOT_W-1:0] dest_i,
  output logic [SLOT_W-1:0] x_o,
  output logic [SLOT_W-1:0] y_o,
  output logic [SLOT_W-1:0] dest_o,
  output logic              go_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      go_o   <= 1'b0;
      x_o    <= SLOT_ACC;
      y_o    <= SLOT_ACC;
      dest_o <= SLOT_ACC;
    end else begin
      go_o <= issue_i;
      if (issue_i) begin
        x_o    <= x_i;
        y_o    <= y_i;
        dest_o <= dest_i;
      end
    end
  end

  p_go_single_r6: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);
  p_sel_held_r6: assert property (@(posedge clk) disable iff (rst)
    (!issue_i && !go_o) |=> ($stable(x_o) && $stable(y_o) && $stable(dest_o)));
endmodule

// File: rtl/simexp_seq.sv
module simexp_seq
  import simexp_seq_pkg::*;
#(
  parameter int CHUNK_W = 16,
  localparam int FIFO_W = 2 * CHUNK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              exp_mode_i,
  input  logic              fifo_empty_i,
  input  logic [FIFO_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic [SLOT_W-1:0] mul_x_o,
  output logic [SLOT_W-1:0] mul_y_o,
  output logic [SLOT_W-1:0] mul_dest_o,
  output logic              mul_go_o,
  input  logic              mul_done_i,
  output logic              done_o
);
  seq_state_t state_q, state_d;

  logic [1:0]        pair;
  logic              last_bit;
  logic              need_mul;
  logic [SLOT_W-1:0] mul_y_slot;
  logic              load_word, shift_word;
  logic              issue;
  logic [SLOT_W-1:0] cmd_y;

  assign load_word  = (state_q == ST_FETCH) && !fifo_empty_i;
  assign shift_word = (state_q == ST_NEXT) && !last_bit;
  assign issue      = (state_q == ST_SQ) || (state_q == ST_MU);
  assign cmd_y      = (state_q == ST_MU) ? mul_y_slot : SLOT_ACC;

  simexp_word_reg #(.CHUNK_W(CHUNK_W)) u_word (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_word),
    .shift_i (shift_word),
    .word_i  (fifo_data_i),
    .pair_o  (pair),
    .last_o  (last_bit)
  );

  simexp_pair_map u_map (
    .pair_i     (pair),
    .y_slot_o   (mul_y_slot),
    .need_mul_o (need_mul)
  );

  simexp_cmd_port u_cmd (
    .clk    (clk),
    .rst    (rst),
    .issue_i(issue),
    .x_i    (SLOT_ACC),
    .y_i    (cmd_y),
    .dest_i (SLOT_ACC),
    .x_o    (mul_x_o),
    .y_o    (mul_y_o),
    .dest_o (mul_dest_o),
    .go_o   (mul_go_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i && exp_mode_i) state_d = ST_FETCH;
      ST_FETCH:   state_d = fifo_empty_i ? ST_IDLE : ST_SQ;
      ST_SQ:      state_d = ST_SQ_WAIT;
      ST_SQ_WAIT: if (mul_done_i) state_d = need_mul ? ST_MU : ST_NEXT;
      ST_MU:      state_d = ST_MU_WAIT;
      ST_MU_WAIT: if (mul_done_i) state_d = ST_NEXT;
      ST_NEXT:    state_d = last_bit ? ST_FETCH : ST_SQ;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      fifo_rd_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      fifo_rd_o <= load_word;
      done_o    <= (state_q == ST_FETCH) && fifo_empty_i;
    end
  end

  // Checks beside the control logic
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !(start_i && exp_mode_i)) |=> (state_q == ST_IDLE));
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_rd_single_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_o |=> !fifo_rd_o);
  p_square_cmd_r4: assert property (@(posedge clk) disable iff (rst)
    (mul_go_o && state_q == ST_SQ_WAIT) |->
      (mul_x_o == SLOT_ACC && mul_y_o == SLOT_ACC && mul_dest_o == SLOT_ACC));
  p_mult_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    (mul_go_o && state_q == ST_MU_WAIT) |->
      (mul_x_o == SLOT_ACC && mul_dest_o == SLOT_ACC && mul_y_o != SLOT_ACC));
  p_wait_no_go_r6: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_SQ_WAIT || state_q == ST_MU_WAIT) && !mul_go_o) |-> !issue);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (state_q == ST_IDLE && !mul_go_o));
endmodule

// File: tb/simexp_seq_tb.sv
module simexp_seq_tb;
  localparam int NV = 6;
  // g0, g1, m, e0, e1, word count, multiplier latency
  localparam longint unsigned V_G0 [NV] = '{3, 7, 2, 12345, 9, 65000};
  localparam longint unsigned V_G1 [NV] = '{5, 11, 3, 54321, 4, 3};
  localparam longint unsigned V_M  [NV] = '{1009, 65521, 40009, 65519, 997, 65521};
  localparam logic [31:0]     V_E0 [NV] = '{32'h00A5, 32'hFFFF, 32'h0000, 32'h1234ABCD, 32'h0, 32'hDEAD0001};
  localparam logic [31:0]     V_E1 [NV] = '{32'h003C, 32'hFFFF, 32'h8001, 32'h0F0F5A5A, 32'h0, 32'h0000BEEF};
  localparam int              V_NW [NV] = '{1, 1, 1, 2, 1, 2};
  localparam int              V_LAT[NV] = '{1, 2, 3, 1, 2, 4};

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, exp_mode_i = 1'b0;
  logic fifo_empty, fifo_rd;
  logic [31:0] fifo_data;
  logic [1:0] mx, my, md;
  logic mgo, mdone, done;

  always #10 clk = ~clk;

  simexp_seq u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .exp_mode_i(exp_mode_i),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_rd_o(fifo_rd),
    .mul_x_o(mx), .mul_y_o(my), .mul_dest_o(md), .mul_go_o(mgo),
    .mul_done_i(mdone), .done_o(done)
  );

  // FIFO model
  logic [31:0] fq [4];
  int f_wr = 0, f_rd = 0, pops = 0;
  assign fifo_empty = (f_rd == f_wr);
  assign fifo_data  = fq[f_rd % 4];
  always @(posedge clk) if (fifo_rd && !fifo_empty) begin f_rd <= f_rd + 1; pops <= pops + 1; end

  // Multiplier stub
  longint unsigned slot [4];
  longint unsigned modm = 1;
  int lat = 1, cnt = 0, sq_cnt = 0, mu_cnt = 0, bad_cmd = 0, overlap = 0;
  logic busy = 1'b0;
  logic [1:0] cx, cy, cd;
  initial mdone = 1'b0;
  always @(posedge clk) begin
    mdone <= 1'b0;
    if (busy) begin
      if (mgo) overlap <= overlap + 1;
      if (cnt == 0) begin
        slot[cd] <= (slot[cx] * slot[cy]) % modm;
        mdone <= 1'b1;
        busy <= 1'b0;
      end else cnt <= cnt - 1;
    end else if (mgo) begin
      busy <= 1'b1; cnt <= lat - 1; cx <= mx; cy <= my; cd <= md;
      if (mx != 2'd3 || md != 2'd3) bad_cmd <= bad_cmd + 1;
      if (my == 2'd3) sq_cnt <= sq_cnt + 1; else mu_cnt <= mu_cnt + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned mpow(input longint unsigned b, input logic [31:0] e, input longint unsigned m);
    longint unsigned r = 1 % m, p = b % m;
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r = (r * p) % m;
      p = (p * p) % m;
    end
    return r;
  endfunction

  task automatic pulse_start(input logic mode);
    @(negedge clk); start_i = 1'b1; exp_mode_i = mode;
    @(negedge clk); start_i = 1'b0; exp_mode_i = 1'b0;
  endtask

  task automatic wait_done(input string req, output bit seen);
    seen = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(posedge clk); #1;
      if (done) seen = 1;
    end
    chk(seen, req, seen, 1);
    if (seen) begin
      @(posedge clk); #1;
      chk(!done, "R10 done single pulse", done, 0);
    end
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(!mgo && !fifo_rd && !done, "R1 reset outputs", {mgo, fifo_rd, done}, 0);
    @(negedge clk); rst = 1'b0;

    // Vector table walk: R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      longint unsigned exp_res;
      int nz;
      logic [31:0] orv;
      modm = V_M[v]; lat = V_LAT[v];
      slot[0] = V_G0[v] % modm; slot[1] = V_G1[v] % modm;
      slot[2] = (slot[0] * slot[1]) % modm; slot[3] = 1 % modm;
      sq_cnt = 0; mu_cnt = 0; pops = 0;
      f_wr = 0; f_rd = 0;
      if (V_NW[v] == 2) begin
        fq[0] = {V_E1[v][31:16], V_E0[v][31:16]};
        fq[1] = {V_E1[v][15:0],  V_E0[v][15:0]};
        f_wr = 2;
        orv = V_E0[v] | V_E1[v];
      end else begin
        fq[0] = {V_E1[v][15:0], V_E0[v][15:0]};
        f_wr = 1;
        orv = (V_E0[v] | V_E1[v]) & 32'hFFFF;
      end
      nz = $countones(orv);
      exp_res = (mpow(V_G0[v], V_E0[v], modm) * mpow(V_G1[v], V_E1[v], modm)) % modm;
      pulse_start(1'b1);
      wait_done("R10 done after run", seen);
      chk(slot[3] == exp_res, "R7 R3 result", slot[3], exp_res);
      chk(sq_cnt == 16 * V_NW[v], "R4 squarings", sq_cnt, 16 * V_NW[v]);
      chk(mu_cnt == nz, "R5 R8 multiplies", mu_cnt, nz);
      chk(pops == V_NW[v], "R8 pops", pops, V_NW[v]);
      chk(bad_cmd == 0, "R5 x/dest slot 3", bad_cmd, 0);
      chk(overlap == 0, "R6 no overlapping go", overlap, 0);
    end

    // R2: start without exponentiation mode is ignored
    sq_cnt = 0; mu_cnt = 0; pops = 0;
    f_wr = 0; f_rd = 0; fq[0] = 32'h00010001; f_wr = 1;
    begin
      int ev = 0;
      pulse_start(1'b0);
      for (int i = 0; i < 30; i++) begin
        @(posedge clk); #1;
        if (done || mgo || fifo_rd) ev++;
      end
      chk(ev == 0, "R2 ignored start outputs", ev, 0);
      chk(pops == 0 && sq_cnt == 0, "R2 ignored start state", pops + sq_cnt, 0);
    end
    // drain that word with a proper start
    slot[3] = 1; modm = 1009; slot[0] = 2; slot[1] = 3; slot[2] = 6; lat = 1;
    pulse_start(1'b1);
    wait_done("R2 accepted after ignore", seen);
    chk(slot[3] == 6, "R7 lowest-bit pair", slot[3], 6);

    // R9: empty FIFO start
    sq_cnt = 0; mu_cnt = 0;
    @(negedge clk); start_i = 1'b1; exp_mode_i = 1'b1;
    @(posedge clk); #1;
    chk(!done, "R9 no done at sample edge", done, 0);
    @(negedge clk); start_i = 1'b0; exp_mode_i = 1'b0;
    @(posedge clk); #1;
    chk(done, "R9 done two edges after start", done, 1);
    @(posedge clk); #1;
    chk(!done, "R10 empty-run done pulse", done, 0);
    chk(sq_cnt + mu_cnt == 0, "R9 no commands", sq_cnt + mu_cnt, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule